// File: doc/BRIEF.md
# Vertical Scanline Counter with Programmable Frame Geometry

This block keeps the vertical position of a raster display. Each pulse on the line strobe, which horizontal timing supplies once per scanline, advances a line counter. The counter returns to line 0 when it has passed the programmed frame length. From the line number and a programmed last-active-line threshold, the block drives a vertical display-enable level. It also drives a one-clock pulse on each return to line 0.

Software programs the geometry through a byte-wide write port made of a register select and a data byte. The frame-length and last-active-line values are assembled from several registers. A layout bit picks between a compact 10-bit arrangement and a wide 12-bit arrangement. In the compact arrangement the upper two bits come from a shared high-bits register. In the wide arrangement the upper four bits come from dedicated extension registers. The programmed length is two less than the real number of lines per frame.

Top module: `vscan_timer`

## Requirements
- R1: After reset every register is 0, line_o is 0, vde_o is 1 (line 0 does not exceed a last-active value of 0) and frame_start_o is 0.
- R2: A write with wr_en_i high stores wr_data_i at the next rising edge into the register chosen by wr_sel_i: 0 layout, 1 length low byte, 2 last-active low byte, 3 shared high bits, 4 length extension, 5 last-active extension. The line counter advances by one only on a clock with line_stb_i high, and otherwise holds.
- R3: With layout bit 0 clear, the length L is {high[5], high[0], length_low}. A frame then lasts L+2 strobes. The extension registers are ignored.
- R4: With layout bit 0 clear, the last-active value E is {high[6], high[1], active_low}.
- R5: With layout bit 0 set, L is {length_ext[3:0], length_low}, and bits 5 and 0 of the shared register are ignored.
- R6: With layout bit 0 set, E is {active_ext[3:0], active_low}, and bits 6 and 1 of the shared register are ignored.
- R7: vde_o is high exactly while line_o is less than or equal to E. Each frame therefore has min(E+1, L+2) enabled lines.
- R8: A strobe taken while line_o is at least L+1 sets line_o to 0. frame_start_o is high for exactly the one clock after that strobe, and is low at every other time.
- R9: Writes act on the very next clock: a new E changes vde_o at once. If line_o already lies beyond a newly written L+1, the next strobe returns the counter to 0.
- R10: When a write and a strobe fall on the same clock, the strobe is judged against the register values held before that write.
- R11: The counter is 13 bits wide. With L = 4095 it reaches line 4096 and the frame lasts 4097 strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | 8 | Write data |
| line_stb_i | input | 1 | One pulse per scanline |
| line_o | output | 13 | Current line number |
| vde_o | output | 1 | Vertical display enable |
| frame_start_o | output | 1 | One-clock pulse on return to line 0 |

## Verification
A register write and a line strobe can land on the same clock edge. When they do, the counter must compare against the frame length held before the write. The bench provokes this twice. First, on the last line of a short frame it rewrites the length to a larger value together with the strobe, and expects a wrap with a frame-start pulse. Second, one line earlier it rewrites the length to a smaller value together with the strobe, and expects a plain advance, with the wrap following on the next strobe.

// File: rtl/vscan_pkg.sv
package vscan_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned EXT_W  = 4;
  localparam int unsigned THR_W  = DATA_W + EXT_W;   // 12-bit wide layout
  localparam int unsigned LINE_W = THR_W + 1;        // room for L+1

  typedef enum logic [SEL_W-1:0] {
    SEL_MODE  = 3'd0,
    SEL_LEN   = 3'd1,
    SEL_ACT   = 3'd2,
    SEL_HIGH  = 3'd3,
    SEL_LENX  = 3'd4,
    SEL_ACTX  = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic [DATA_W-1:0] mode;
    logic [DATA_W-1:0] len_lo;
    logic [DATA_W-1:0] act_lo;
    logic [DATA_W-1:0] high;
    logic [EXT_W-1:0]  len_ext;
    logic [EXT_W-1:0]  act_ext;
  } geom_regs_t;

  // positions in the shared high-bits register (compact layout)
  localparam int unsigned LEN_B8 = 0;
  localparam int unsigned LEN_B9 = 5;
  localparam int unsigned ACT_B8 = 1;
  localparam int unsigned ACT_B9 = 6;
endpackage

// File: rtl/vscan_regs.sv
module vscan_regs
  import vscan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output geom_regs_t        regs_o
);
  geom_regs_t regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (wr_en_i) begin
      unique case (reg_sel_e'(wr_sel_i))
        SEL_MODE: regs_q.mode    <= wr_data_i;
        SEL_LEN:  regs_q.len_lo  <= wr_data_i;
        SEL_ACT:  regs_q.act_lo  <= wr_data_i;
        SEL_HIGH: regs_q.high    <= wr_data_i;
        SEL_LENX: regs_q.len_ext <= wr_data_i[EXT_W-1:0];
        SEL_ACTX: regs_q.act_ext <= wr_data_i[EXT_W-1:0];
        default:  ;
      endcase
    end
  end

  assign regs_o = regs_q;

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == SEL_LEN |=> regs_q.len_lo == $past(wr_data_i));
endmodule

// File: rtl/vscan_thresh.sv
module vscan_thresh
  import vscan_pkg::*;
(
  input  geom_regs_t        regs_i,
  output logic [THR_W-1:0]  len_o,
  output logic [THR_W-1:0]  act_o
);
  logic wide;
  assign wide = regs_i.mode[0];

  always_comb begin
    if (wide) begin
      len_o = {regs_i.len_ext, regs_i.len_lo};
      act_o = {regs_i.act_ext, regs_i.act_lo};
    end else begin
      len_o = {2'b00, regs_i.high[LEN_B9], regs_i.high[LEN_B8], regs_i.len_lo};
      act_o = {2'b00, regs_i.high[ACT_B9], regs_i.high[ACT_B8], regs_i.act_lo};
    end
  end

  always_comb begin
    assert_compact_top_zero_R3: assert (wide || (len_o[THR_W-1:DATA_W+2] == '0 &&
                                                 act_o[THR_W-1:DATA_W+2] == '0));
  end
endmodule

// File: rtl/vscan_line_cnt.sv
module vscan_line_cnt
  import vscan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [THR_W-1:0]  len_i,
  output logic [LINE_W-1:0] line_o,
  output logic              wrap_o
);
  logic [LINE_W-1:0] line_q;
  logic              wrap_q;
  logic [LINE_W-1:0] last;

  assign last = LINE_W'(len_i) + LINE_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (stb_i) begin
        if (line_q >= last) begin
          line_q <= '0;
          wrap_q <= 1'b1;
        end else begin
          line_q <= line_q + 1'b1;
        end
      end
    end
  end

  assign line_o = line_q;
  assign wrap_o = wrap_q;

  assert_hold_no_stb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(line_q));
  assert_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && line_q < last |=> line_q == $past(line_q) + 1'b1);
  assert_wrap_to_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && line_q >= last |=> line_q == '0 && wrap_q);
  assert_pulse_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |=> !wrap_q);
  assert_pulse_at_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |-> line_q == '0);
endmodule

// File: rtl/vscan_timer.sv
module vscan_timer
  import vscan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              line_stb_i,
  output logic [LINE_W-1:0] line_o,
  output logic              vde_o,
  output logic              frame_start_o
);
  geom_regs_t        regs;
  logic [THR_W-1:0]  len_thr;
  logic [THR_W-1:0]  act_thr;

  vscan_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .regs_o    (regs)
  );

  vscan_thresh u_thresh (
    .regs_i (regs),
    .len_o  (len_thr),
    .act_o  (act_thr)
  );

  vscan_line_cnt u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (line_stb_i),
    .len_i  (len_thr),
    .line_o (line_o),
    .wrap_o (frame_start_o)
  );

  assign vde_o = (line_o <= LINE_W'(act_thr));

  assert_vde_on_at_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> vde_o);
endmodule

// File: tb/sim_vscan_timer.sv
`timescale 1ns/1ps
module sim_vscan_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        line_stb_i = 1'b0;
  logic [12:0] line_o;
  logic        vde_o;
  logic        frame_start_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  vscan_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .line_stb_i(line_stb_i), .line_o(line_o),
    .vde_o(vde_o), .frame_start_o(frame_start_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // drive on one negedge, sample at the next one
  task automatic cyc(input logic we, input logic [2:0] sel, input logic [7:0] d, input logic stb);
    wr_en_i = we; wr_sel_i = sel; wr_data_i = d; line_stb_i = stb;
    @(negedge clk_i);
    wr_en_i = 1'b0; line_stb_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    cyc(1'b1, sel, d, 1'b0);
  endtask

  task automatic stb(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'd0, 1'b1);
  endtask

  // from line 0: count strobes per frame and enabled lines
  task automatic measure(output int len, output int act);
    len = 0; act = 0;
    for (int i = 0; i < 6000; i++) begin
      if (vde_o) act++;
      stb(1);
      len++;
      if (frame_start_o) break;
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #1;
    check("R1", "line after reset", line_o, 0);
    check("R1", "vde after reset", vde_o, 1);
    check("R1", "frame_start after reset", frame_start_o, 0);
    do_reset();
  endtask

  task automatic t_hold();
    do_reset();
    wr(3'd1, 8'd20);
    repeat (5) @(negedge clk_i);
    check("R2", "line held without strobe", line_o, 0);
    stb(3);
    check("R2", "line after 3 strobes", line_o, 3);
    repeat (3) @(negedge clk_i);
    check("R2", "line held again", line_o, 3);
  endtask

  task automatic t_compact();
    int len, act;
    do_reset();
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h23);
    wr(3'd2, 8'h12);
    wr(3'd3, 8'b0010_0010);  // length bit9, active bit8
    wr(3'd4, 8'h0F);
    wr(3'd5, 8'h0F);
    measure(len, act);
    check("R3", "compact frame length", len, 549);
    check("R4", "compact enabled lines", act, 275);
    wr(3'd3, 8'b0100_0001);  // length bit8, active bit9
    measure(len, act);
    check("R3", "compact frame length b8", len, 293);
    check("R7", "all lines enabled when E beyond frame", act, 293);
  endtask

  task automatic t_wide();
    int len, act;
    do_reset();
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h05);
    wr(3'd4, 8'h02);
    wr(3'd2, 8'h00);
    wr(3'd5, 8'h01);
    wr(3'd3, 8'hFF);
    measure(len, act);
    check("R5", "wide frame length", len, 519);
    check("R6", "wide enabled lines", act, 257);
  endtask

  task automatic t_max();
    int len, act, top;
    do_reset();
    wr(3'd0, 8'h01);
    wr(3'd1, 8'hFF);
    wr(3'd4, 8'h0F);
    stb(4096);
    top = line_o;
    check("R11", "deepest line index", top, 4096);
    do_reset();
    wr(3'd0, 8'h01);
    wr(3'd1, 8'hFF);
    wr(3'd4, 8'h0F);
    measure(len, act);
    check("R11", "max frame length", len, 4097);
  endtask

  task automatic t_pulse();
    do_reset();
    wr(3'd1, 8'd1);     // frame of 3 lines
    stb(2);
    check("R8", "no pulse mid-frame", frame_start_o, 0);
    stb(1);
    check("R8", "pulse on wrap", frame_start_o, 1);
    check("R8", "line zero on wrap", line_o, 0);
    @(negedge clk_i);
    check("R8", "pulse lasts one clock", frame_start_o, 0);
  endtask

  task automatic t_live_write();
    do_reset();
    wr(3'd1, 8'd10);
    wr(3'd2, 8'd9);
    stb(8);
    check("R7", "vde at line 8 with E=9", vde_o, 1);
    wr(3'd2, 8'd5);
    check("R9", "vde drops after E rewrite", vde_o, 0);
    wr(3'd1, 8'd3);
    check("R9", "no move on length write", line_o, 8);
    stb(1);
    check("R9", "wrap past shrunk length", line_o, 0);
    check("R9", "pulse past shrunk length", frame_start_o, 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(3'd1, 8'd3);     // last line 4
    stb(4);
    cyc(1'b1, 3'd1, 8'd10, 1'b1);
    check("R10", "wrap uses old length", line_o, 0);
    check("R10", "pulse uses old length", frame_start_o, 1);
    do_reset();
    wr(3'd1, 8'd3);
    stb(3);
    cyc(1'b1, 3'd1, 8'd1, 1'b1);
    check("R10", "advance uses old length", line_o, 4);
    check("R10", "no pulse on advance", frame_start_o, 0);
    stb(1);
    check("R9", "wrap on next strobe", line_o, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_compact();
    t_wide();
    t_max();
    t_pulse();
    t_live_write();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule